// File: doc/BRIEF.md
# ALU with Immediate Expansion and Flags

This block is the integer execution unit of a 32-bit core. Each cycle it takes two source operands and an operation code. The operation is applied either to the second register operand or to a 16-bit constant that the block widens itself. The result is produced combinationally, in the same cycle. A four-bit condition register holds Zero, Negative, Overflow and Carry, and the block loads it on the clock edge whenever the instruction asks for a flag update.

The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and a shift. The direction of the shift comes from the sign of its amount. In register form, operation code 111 does not name a shift directly. It opens a small space of special operations: logical shift, arithmetic shift, and a select that picks one of the two sources according to a condition computed outside the block. The carry that add-with-carry and subtract-with-borrow consume is the stored Carry flag.

Top module: `alu_imm_flags`

## Requirements
- R1: Operation codes 000, 001, 010 and 011 compute a+b, a+b+C, a+~b+1 and a+~b+C, where C is the stored Carry flag. In register form b is srcB. Register-form codes 100, 101 and 110 compute a AND b, a OR b and a XOR b.
- R2: In immediate form (immForm=1) with codes 000 to 011, 101 or 110, b is {imm16, 16'h0000} when immHigh=1 and {16'h0000, imm16} when immHigh=0.
- R3: In immediate form with code 100 (AND), the half of b that does not hold imm16 is 16'hFFFF instead of zero.
- R4: In immediate form with code 111, b is imm16 sign-extended to 32 bits and the operation is a shift. immHigh=0 selects a logical shift and immHigh=1 an arithmetic shift.
- R5: The shift amount is b[5:0] read as a two's-complement number. Values 1..31 shift srcA left, -1..-31 shift it right by the magnitude, and 0 returns srcA unchanged.
- R6: For codes 000 to 011, Carry becomes the carry out of bit 31 of the addition. Overflow becomes 1 exactly when the true signed result does not fit in 32 bits.
- R7: On a left shift by k, Carry becomes srcA[32-k]. Right shifts, shifts by 0, logic operations and select clear Carry. Overflow is cleared for every operation except codes 000 to 011.
- R8: When setFlags=1, the flag outputs take their new values at the next rising clock edge. Zero is set when the result is zero, and Negative copies result bit 31. When setFlags=0, all four flags keep their values.
- R9: In register form with code 111, specialCode 10xxx is a logical shift and 11xxx an arithmetic shift, both by the amount in srcB. specialCode 00000 returns srcA when condTrue=1 and srcB when condTrue=0.
- R10: In register form with code 111, any other specialCode value (01xxx, or 00xxx other than 00000) gives result 0 and leaves all four flags unchanged, even when setFlags=1.
- R11: While rstN is low, all four flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of the flag register |
| immForm | input | 1 | 1 = second operand comes from imm16, 0 = from srcB |
| opCode | input | 3 | Operation code |
| setFlags | input | 1 | Load the flag register at the next edge |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand (register form) |
| imm16 | input | 16 | Constant (immediate form) |
| immHigh | input | 1 | Constant placement, or shift kind for immediate shifts |
| specialCode | input | 5 | Special operation selector (register form, code 111) |
| condTrue | input | 1 | Externally evaluated condition for select |
| result | output | 32 | Operation result |
| flagZ | output | 1 | Stored Zero flag |
| flagN | output | 1 | Stored Negative flag |
| flagV | output | 1 | Stored Overflow flag |
| flagC | output | 1 | Stored Carry flag |

## Verification
The bench builds the block with its default width of 32, which is the only width that fits the 16-bit constant. At that width, a full sweep is within reach across every operation code, both forms, both placement bits and both flag-enable settings, on operands chosen at the sign and carry boundaries. Shifts of every defined amount from -31 to 31 are swept in both kinds and both forms. All 32 special sub-codes are swept with both condition values. Because the stored Carry feeds add-with-carry and subtract-with-borrow, the sweeps run back to back, so each carry-consuming operation sees whatever Carry the operation before it left, set or clear.

// File: rtl/alu_imm_pkg.sv
package alu_imm_pkg;

  typedef enum logic [2:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SHIFT,
    CLS_SELECT,
    CLS_RSVD
  } opClass_e;

  // carrySel: 0 = constant zero, 1 = constant one, 2 = stored carry flag
  // logicOp : 0 = and, 1 = or, 2 = xor
  typedef struct packed {
    opClass_e   cls;
    logic       invertB;
    logic [1:0] carrySel;
    logic [1:0] logicOp;
    logic       shiftArith;
    logic       useImm;
    logic       immFill;
    logic       immSext;
    logic       flagWe;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_imm_pkg::*;
(
  input  logic       immForm,
  input  logic [2:0] opCode,
  input  logic       setFlags,
  input  logic       immHigh,
  input  logic [4:0] specialCode,
  output strobe_t    strobes
);

  always_comb begin
    strobes          = '0;
    strobes.cls      = CLS_ARITH;
    strobes.useImm   = immForm;
    strobes.flagWe   = setFlags;
    case (opCode)
      3'd0: strobes.carrySel = 2'd0;
      3'd1: strobes.carrySel = 2'd2;
      3'd2: begin
        strobes.invertB  = 1'b1;
        strobes.carrySel = 2'd1;
      end
      3'd3: begin
        strobes.invertB  = 1'b1;
        strobes.carrySel = 2'd2;
      end
      3'd4: begin
        strobes.cls     = CLS_LOGIC;
        strobes.logicOp = 2'd0;
        strobes.immFill = 1'b1;
      end
      3'd5: begin
        strobes.cls     = CLS_LOGIC;
        strobes.logicOp = 2'd1;
      end
      3'd6: begin
        strobes.cls     = CLS_LOGIC;
        strobes.logicOp = 2'd2;
      end
      default: begin
        if (immForm) begin
          strobes.cls        = CLS_SHIFT;
          strobes.immSext    = 1'b1;
          strobes.shiftArith = immHigh;
        end else begin
          casez (specialCode)
            5'b1????: begin
              strobes.cls        = CLS_SHIFT;
              strobes.shiftArith = specialCode[3];
            end
            5'b00000: strobes.cls = CLS_SELECT;
            default: begin
              strobes.cls    = CLS_RSVD;
              strobes.flagWe = 1'b0;
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         value,
  input  logic [$clog2(WIDTH):0]   amount,
  input  logic                     arith,
  output logic [WIDTH-1:0]         shifted,
  output logic                     carryOut
);

  localparam int CW = $clog2(WIDTH);

  logic          isRight;
  logic [CW-1:0] cnt;
  logic [WIDTH:0] leftWide;
  logic [WIDTH-1:0] rightVal;

  assign isRight  = amount[CW];
  assign cnt      = isRight ? (~amount[CW-1:0] + 1'b1) : amount[CW-1:0];
  assign leftWide = {1'b0, value} << cnt;
  assign rightVal = arith ? WIDTH'($signed(value) >>> cnt) : (value >> cnt);

  always_comb begin
    if (isRight) begin
      shifted  = rightVal;
      carryOut = 1'b0;
    end else begin
      shifted  = leftWide[WIDTH-1:0];
      carryOut = leftWide[WIDTH];
    end
  end

endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_imm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [WIDTH-1:0]   srcA,
  input  logic [WIDTH-1:0]   srcB,
  input  logic [WIDTH/2-1:0] immVal,
  input  logic               immHigh,
  input  logic               condTrue,
  output logic [WIDTH-1:0]   result,
  output logic [3:0]         flagReg
);

  localparam int HALF = WIDTH / 2;
  localparam int SHW  = $clog2(WIDTH) + 1;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] immWide;
  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] bEff;
  logic             carryIn;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic             shiftCarry;
  logic [3:0]       flagNext;
  logic             nextV;
  logic             nextC;

  // immediate widening
  always_comb begin
    if (strobes.immSext)
      immWide = {{HALF{immVal[HALF-1]}}, immVal};
    else if (immHigh)
      immWide = {immVal, {HALF{strobes.immFill}}};
    else
      immWide = {{HALF{strobes.immFill}}, immVal};
  end

  assign opB  = strobes.useImm ? immWide : srcB;
  assign bEff = strobes.invertB ? ~opB : opB;

  always_comb begin
    case (strobes.carrySel)
      2'd1:    carryIn = 1'b1;
      2'd2:    carryIn = flagReg[0];
      default: carryIn = 1'b0;
    endcase
  end

  assign sum = {1'b0, srcA} + {1'b0, bEff} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    case (strobes.logicOp)
      2'd0:    logicRes = srcA & opB;
      2'd1:    logicRes = srcA | opB;
      default: logicRes = srcA ^ opB;
    endcase
  end

  alu_shift #(.WIDTH(WIDTH)) uShift (
    .value    (srcA),
    .amount   (opB[SHW-1:0]),
    .arith    (strobes.shiftArith),
    .shifted  (shiftRes),
    .carryOut (shiftCarry)
  );

  always_comb begin
    nextV = 1'b0;
    nextC = 1'b0;
    case (strobes.cls)
      CLS_ARITH: begin
        result = sum[WIDTH-1:0];
        nextC  = sum[WIDTH];
        nextV  = (srcA[MSB] == bEff[MSB]) && (sum[MSB] != srcA[MSB]);
      end
      CLS_LOGIC:  result = logicRes;
      CLS_SHIFT: begin
        result = shiftRes;
        nextC  = shiftCarry;
      end
      CLS_SELECT: result = condTrue ? srcA : srcB;
      default:    result = '0;
    endcase
  end

  // flag order {Z, N, V, C}
  assign flagNext = {(result == '0), result[MSB], nextV, nextC};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flagReg <= 4'b0000;
    else if (strobes.flagWe)
      flagReg <= flagNext;
  end

  a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagWe |=> $stable(flagReg));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagWe |=> (flagReg[3] == ($past(result) == '0)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagWe && (strobes.cls != CLS_ARITH)) |=> !flagReg[1]);

  a_r7_right_clears_carry: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagWe && (strobes.cls == CLS_SHIFT) && opB[SHW-1]) |=> !flagReg[0]);

  a_r10_reserved_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cls == CLS_RSVD) |=> $stable(flagReg));

endmodule

// File: rtl/alu_imm_flags.sv
module alu_imm_flags
  import alu_imm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               immForm,
  input  logic [2:0]         opCode,
  input  logic               setFlags,
  input  logic [WIDTH-1:0]   srcA,
  input  logic [WIDTH-1:0]   srcB,
  input  logic [WIDTH/2-1:0] imm16,
  input  logic               immHigh,
  input  logic [4:0]         specialCode,
  input  logic               condTrue,
  output logic [WIDTH-1:0]   result,
  output logic               flagZ,
  output logic               flagN,
  output logic               flagV,
  output logic               flagC
);

  strobe_t    strobes;
  logic [3:0] flagReg;

  alu_ctrl uCtrl (
    .immForm     (immForm),
    .opCode      (opCode),
    .setFlags    (setFlags),
    .immHigh     (immHigh),
    .specialCode (specialCode),
    .strobes     (strobes)
  );

  alu_dp #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .immVal   (imm16),
    .immHigh  (immHigh),
    .condTrue (condTrue),
    .result   (result),
    .flagReg  (flagReg)
  );

  assign {flagZ, flagN, flagV, flagC} = flagReg;

endmodule

// File: tb/tb_alu_imm_flags.sv
`timescale 1ns/1ps
module tb_alu_imm_flags;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        immForm = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        setFlags = 1'b0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm16 = '0;
  logic        immHigh = 1'b0;
  logic [4:0]  specialCode = '0;
  logic        condTrue = 1'b0;
  logic [31:0] result;
  logic        flagZ, flagN, flagV, flagC;

  always #4 clk = ~clk;

  alu_imm_flags dut (
    .clk(clk), .rstN(rstN), .immForm(immForm), .opCode(opCode),
    .setFlags(setFlags), .srcA(srcA), .srcB(srcB), .imm16(imm16),
    .immHigh(immHigh), .specialCode(specialCode), .condTrue(condTrue),
    .result(result), .flagZ(flagZ), .flagN(flagN), .flagV(flagV), .flagC(flagC)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [3:0]  mFlags;          // model {Z,N,V,C}
  logic [31:0] expRes;
  logic        expV, expC, expRsvd;
  string       tagRes, tagFlg;

  logic [31:0] opnd [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                            32'h0000_FFFF, 32'hA5A5_0F0F};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic immF, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i16, input logic hi,
                       input logic [4:0] spec, input logic cond, input logic cIn);
    logic [31:0] ob;
    longint sa, sb, sr, ua, ub, ur;
    logic isShift, arith;
    int amt;
    expRsvd = 0; expV = 0; expC = 0; isShift = 0; arith = 0; expRes = '0;
    if (immF) begin
      if (op == 3'd7)      begin ob = {{16{i16[15]}}, i16}; tagRes = "R4"; end
      else if (op == 3'd4) begin ob = hi ? {i16, 16'hFFFF} : {16'hFFFF, i16}; tagRes = "R3"; end
      else                 begin ob = hi ? {i16, 16'h0000} : {16'h0000, i16}; tagRes = "R2"; end
    end else begin
      ob = b; tagRes = "R1";
    end
    tagFlg = "R8";
    sa = longint'($signed(a)); sb = longint'($signed(ob));
    ua = longint'({32'h0, a}); ub = longint'({32'h0, ob});
    case (op)
      3'd0, 3'd1: begin
        sr = sa + sb + ((op == 3'd1 && cIn) ? 1 : 0);
        ur = ua + ub + ((op == 3'd1 && cIn) ? 1 : 0);
        expRes = ur[31:0]; expC = (ur >= 64'sh1_0000_0000);
        expV = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000); tagFlg = "R6";
      end
      3'd2, 3'd3: begin
        sr = sa - sb - ((op == 3'd3 && !cIn) ? 1 : 0);
        ur = ua + (64'shFFFF_FFFF - ub) + ((op == 3'd2 || cIn) ? 1 : 0);
        expRes = ur[31:0]; expC = (ur >= 64'sh1_0000_0000);
        expV = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000); tagFlg = "R6";
      end
      3'd4: expRes = a & ob;
      3'd5: expRes = a | ob;
      3'd6: expRes = a ^ ob;
      default: begin
        if (immF) begin isShift = 1; arith = hi; end
        else if (spec[4]) begin isShift = 1; arith = spec[3]; tagRes = "R9"; end
        else if (spec == 5'd0) begin expRes = cond ? a : b; tagRes = "R9"; tagFlg = "R7"; end
        else begin expRsvd = 1; tagRes = "R10"; tagFlg = "R10"; end
      end
    endcase
    if (isShift) begin
      amt = int'($signed(ob[5:0]));
      tagFlg = "R7";
      if (amt >= 0) begin
        expRes = a << amt;
        expC = (amt > 0) ? a[32-amt] : 1'b0;
        if (tagRes != "R9") tagRes = (amt == 0) ? "R5" : tagRes;
      end else begin
        expRes = a;
        for (int k = 0; k < -amt; k++) expRes = {arith & expRes[31], expRes[31:1]};
      end
    end
  endtask

  task automatic step(input logic immF, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] i16, input logic hi,
                      input logic setF, input logic [4:0] spec, input logic cond);
    @(negedge clk);
    immForm = immF; opCode = op; srcA = a; srcB = b; imm16 = i16; immHigh = hi;
    setFlags = setF; specialCode = spec; condTrue = cond;
    model(immF, op, a, b, i16, hi, spec, cond, mFlags[0]);
    #1;
    check(tagRes, result, expRes);
    if (setF && !expRsvd)
      mFlags = {(expRes == 32'h0), expRes[31], expV, expC};
    else if (!setF)
      tagFlg = "R8";
    @(posedge clk);
    #1;
    check(tagFlg, {28'h0, flagZ, flagN, flagV, flagC}, {28'h0, mFlags});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mFlags = 4'b0000;
    // drive a flag-setting op during reset: flags must stay clear (R11)
    setFlags = 1'b1; srcA = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1;
    check("R11", {28'h0, flagZ, flagN, flagV, flagC}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    setFlags = 1'b0;

    // operation sweep: arithmetic and logic, both forms (R1 R2 R3 R6 R8)
    for (int f = 0; f < 2; f++)
      for (int op = 0; op < 7; op++)
        for (int h = 0; h < 2; h++)
          for (int s = 0; s < 2; s++)
            for (int ai = 0; ai < 8; ai++)
              for (int bi = 0; bi < 8; bi++)
                step(f[0], op[2:0], opnd[ai], opnd[bi], opnd[bi][15:0], h[0],
                     s[0], 5'(bi), 1'b0);

    // shift sweep, every defined amount (R4 R5 R7 R9)
    for (int f = 0; f < 2; f++)
      for (int kind = 0; kind < 2; kind++)
        for (int amt = -31; amt <= 31; amt++)
          for (int ai = 2; ai < 6; ai++) begin
            logic [31:0] av = (ai == 2) ? 32'hF000_000F : opnd[ai+2];
            if (f == 1)
              step(1'b1, 3'd7, av, 32'h0, 16'(amt), kind[0], 1'b1, 5'd0, 1'b0);
            else
              step(1'b0, 3'd7, av, 32'(amt), 16'h0, 1'b0, 1'b1,
                   {1'b1, kind[0], 3'(ai)}, 1'b0);
          end

    // special sub-code sweep: select and reserved codes (R9 R10)
    for (int sc = 0; sc < 32; sc++)
      for (int c = 0; c < 2; c++)
        for (int pi = 0; pi < 4; pi++) begin
          // set distinctive flags first so an illegal update is visible
          step(1'b0, 3'd2, 32'h0, 32'h1, 16'h0, 1'b0, 1'b1, 5'd0, 1'b0);
          step(1'b0, 3'd7, opnd[pi+4], opnd[pi], 16'h0, 1'b0, 1'b1, 5'(sc), c[0]);
        end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule